// File: doc/BRIEF.md
# PCI Type-0 Configuration Header Responder

This block holds the 64-byte type-0 header of a PCI function and answers configuration requests of one, two or four bytes at any byte offset inside a 256-byte window. Identification, class and the fixed header fields come from elaboration parameters. Command, status, cache-line size, latency timer, interrupt line, the expansion ROM register and six base address registers (BARs) are writable. A request is presented for one cycle. The block acknowledges it on the next cycle and returns read data in little-endian order: the byte at the requested offset is in bits 7:0.

Each BAR has a power-of-two size parameter, an initial value and a legacy-I/O flag. Software finds the size of a BAR by writing all ones to it and reading the result back. A later non-zero write sets the decoded address that the block drives for that BAR and raises a single range-change pulse, so the surrounding fabric can re-route its address map. The attribute bits of a BAR cannot be written. A BAR size that is neither zero nor a power of two is rejected at elaboration, and so is an interrupt-pin value above 4.

Top module: `cfg_space_responder`

## Requirements
- R1: The size code selects 1 byte (0), 2 bytes (1) or 4 bytes (2). Code 3 raises `rsp_err` together with the acknowledge, returns zero read data and changes no state.
- R2: Every request is acknowledged exactly one cycle after `req_valid`. Read data holds the bytes at offset, offset+1, ... in ascending byte lanes, and lanes beyond the access size are zero. Write responses carry zero data. The header layout: vendor 0x00, device 0x02, command 0x04, status 0x06, revision 0x08, programming interface 0x09, subclass 0x0A, class 0x0B, cache line 0x0C, latency 0x0D, header type 0x0E, self-test 0x0F, BARs 0x10 to 0x24 in steps of 4, card-bus pointer 0x28, subsystem vendor 0x2C, subsystem 0x2E, ROM 0x30, capability pointer 0x34, interrupt line 0x3C, interrupt pin 0x3D, minimum grant 0x3E, maximum latency 0x3F.
- R3: Any byte at offset 0x40 or above reads as zero, including bytes that an unaligned access crosses into. Writes that start there are dropped without an error.
- R4: A 32-bit write of 0xFFFFFFFF to a non-legacy BAR stores ~(size-1) with the old attribute bits kept. A BAR of size zero then reads back only its attribute bits. A sizing write raises no pulse and leaves the decoded address unchanged.
- R5: For any other 32-bit BAR write, the attribute bits of the written value are replaced by those of the old value. Bit 0 of the old value set means the low 2 bits are attributes; clear means the low 4 bits are.
- R6: A BAR write that is not a sizing write and has a non-zero result after masking sets that BAR's `bar_addr` slice to the masked value. It also raises `bar_range_chg` for one cycle, in the same cycle as the acknowledge. A write that masks to zero changes neither.
- R7: A legacy BAR reads as zero, ignores writes and drives a constant decoded address equal to the legacy base plus its initial value.
- R8: A 32-bit write of 0xFFFFFFFE to the ROM register at 0x30 stores 0xFFFFFFFF. Any other 32-bit value is stored unchanged.
- R9: Byte writes update the interrupt line (0x3C), the cache line (0x0C) and the latency timer (0x0D). Byte writes to 0x3D, 0x3E, 0x3F, 0x0B and 0x08 are ignored without an error. A byte write to any other header offset raises `rsp_err` and changes nothing.
- R10: 2-byte writes store 16 bits into command (0x04) or status (0x06), and the low byte into the cache line (0x0C). A 4-byte write at 0x04 stores its low 16 bits into command and leaves status alone. Every other write below 0x40 that is not a BAR or ROM write raises `rsp_err` and changes nothing.
- R11: Reset loads every header field from its parameter and clears the reserved bytes 0x35 to 0x3B. It zeroes the decoded address of every non-legacy BAR and leaves acknowledge, error and range-change low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size code |
| req_offset | input | 8 | Byte offset in configuration space |
| req_wdata | input | 32 | Write data, lowest addressed byte in bits 7:0 |
| rsp_ack | output | 1 | Acknowledge, one cycle after the request |
| rsp_rdata | output | 32 | Little-endian read data |
| rsp_err | output | 1 | Invalid size or disallowed write |
| bar_addr | output | 192 | Decoded address of each BAR, BAR i in bits 32i+31:32i |
| bar_range_chg | output | 1 | One-cycle pulse when any decoded BAR address is set |

## Verification
Two things can happen in the same cycle: the acknowledge of a BAR address write and the range-change pulse with the new decoded address. The bench provokes this with back-to-back requests: the write is followed at once by a read of the same BAR, with no idle cycle between them. It judges that the pulse, the new address and the write acknowledge appear in one sampled cycle, and that the read acknowledged in the next cycle already returns the stored value. It also checks that the pulse has dropped by then.

// File: rtl/cfgsp_pkg.sv
package cfgsp_pkg;

  localparam int NUM_BARS  = 6;
  localparam int HDR_BYTES = 64;
  localparam int HDR_BITS  = HDR_BYTES * 8;
  localparam int WORD_W    = 32;

  // Offsets that the write decoder and the read gather depend on
  localparam logic [7:0] OFF_CMD     = 8'h04;
  localparam logic [7:0] OFF_STAT    = 8'h06;
  localparam logic [7:0] OFF_REV     = 8'h08;
  localparam logic [7:0] OFF_CLASS   = 8'h0B;
  localparam logic [7:0] OFF_CLS     = 8'h0C;
  localparam logic [7:0] OFF_LAT     = 8'h0D;
  localparam logic [7:0] OFF_BAR0    = 8'h10;
  localparam logic [7:0] OFF_ROM     = 8'h30;
  localparam logic [7:0] OFF_ILINE   = 8'h3C;
  localparam logic [7:0] OFF_IPIN    = 8'h3D;
  localparam logic [7:0] OFF_MINGNT  = 8'h3E;
  localparam logic [7:0] OFF_MAXLAT  = 8'h3F;
  localparam logic [7:0] OFF_DEVSPEC = 8'h40;

  localparam logic [WORD_W-1:0] IO_ATTR_MASK  = 32'h0000_0003;
  localparam logic [WORD_W-1:0] MEM_ATTR_MASK = 32'h0000_000F;
  localparam logic [WORD_W-1:0] ROM_PROBE_VAL = 32'hFFFF_FFFE;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } acc_size_e;

  typedef struct packed {
    logic iline;
    logic cls;
    logic lat;
    logic cmd;
    logic stat;
    logic rom;
  } hdr_we_t;

  function automatic logic pow2_or_zero(input logic [WORD_W-1:0] v);
    return (v & (v - 32'd1)) == 32'd0;
  endfunction

endpackage

// File: rtl/cfgsp_decode.sv
module cfgsp_decode
  import cfgsp_pkg::*;
(
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [1:0]          req_size,
  input  logic [7:0]          req_offset,
  output hdr_we_t             hdr_we,
  output logic [NUM_BARS-1:0] bar_we,
  output logic                bad_access
);

  logic                in_hdr;
  logic                word_wr;
  logic [NUM_BARS-1:0] bar_hit;
  acc_size_e           size_e;

  assign size_e  = acc_size_e'(req_size);
  assign in_hdr  = req_offset < OFF_DEVSPEC;
  assign word_wr = req_valid && req_write && in_hdr && (size_e == SZ_WORD);

  for (genvar gi = 0; gi < NUM_BARS; gi++) begin : g_bar_hit
    assign bar_hit[gi] = (req_offset == 8'(OFF_BAR0 + 8'(4 * gi)));
    assign bar_we[gi]  = word_wr && bar_hit[gi];
  end

  always_comb begin
    hdr_we     = '0;
    bad_access = 1'b0;
    if (req_valid) begin
      if (size_e == SZ_BAD) begin
        bad_access = 1'b1;
      end else if (req_write && in_hdr) begin
        unique case (size_e)
          SZ_BYTE: begin
            if (req_offset == OFF_ILINE)      hdr_we.iline = 1'b1;
            else if (req_offset == OFF_CLS)   hdr_we.cls   = 1'b1;
            else if (req_offset == OFF_LAT)   hdr_we.lat   = 1'b1;
            else if (req_offset == OFF_IPIN || req_offset == OFF_MINGNT ||
                     req_offset == OFF_MAXLAT || req_offset == OFF_CLASS ||
                     req_offset == OFF_REV)   bad_access   = 1'b0;
            else                              bad_access   = 1'b1;
          end
          SZ_HALF: begin
            if (req_offset == OFF_CMD)        hdr_we.cmd  = 1'b1;
            else if (req_offset == OFF_STAT)  hdr_we.stat = 1'b1;
            else if (req_offset == OFF_CLS)   hdr_we.cls  = 1'b1;
            else                              bad_access  = 1'b1;
          end
          SZ_WORD: begin
            if (|bar_hit)                     bad_access  = 1'b0;
            else if (req_offset == OFF_ROM)   hdr_we.rom  = 1'b1;
            else if (req_offset == OFF_CMD)   hdr_we.cmd  = 1'b1;
            else                              bad_access  = 1'b1;
          end
          default: bad_access = 1'b1;
        endcase
      end
    end
  end

  // R10: at most one header register is written per request
  always_comb begin
    assert_one_target_R10: assert ($onehot0(hdr_we));
  end

endmodule

// File: rtl/cfgsp_hdr_regs.sv
module cfgsp_hdr_regs
  import cfgsp_pkg::*;
#(
  parameter logic [15:0] CMD_INIT   = 16'h0000,
  parameter logic [15:0] STAT_INIT  = 16'h0000,
  parameter logic [7:0]  CLS_INIT   = 8'h00,
  parameter logic [7:0]  LAT_INIT   = 8'h00,
  parameter logic [7:0]  ILINE_INIT = 8'h00,
  parameter logic [31:0] ROM_INIT   = 32'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  hdr_we_t           we,
  input  logic [WORD_W-1:0] wdata,
  output logic [15:0]       cmd,
  output logic [15:0]       stat,
  output logic [7:0]        cls,
  output logic [7:0]        lat,
  output logic [7:0]        iline,
  output logic [WORD_W-1:0] rom
);

  logic [15:0]       cmd_d, stat_d;
  logic [7:0]        cls_d, lat_d, iline_d;
  logic [WORD_W-1:0] rom_d;

  always_comb begin
    cmd_d   = wdata[15:0];
    stat_d  = wdata[15:0];
    cls_d   = wdata[7:0];
    lat_d   = wdata[7:0];
    iline_d = wdata[7:0];
    rom_d   = (wdata == ROM_PROBE_VAL) ? '1 : wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd   <= CMD_INIT;
      stat  <= STAT_INIT;
      cls   <= CLS_INIT;
      lat   <= LAT_INIT;
      iline <= ILINE_INIT;
      rom   <= ROM_INIT;
    end else begin
      if (we.cmd)   cmd   <= cmd_d;
      if (we.stat)  stat  <= stat_d;
      if (we.cls)   cls   <= cls_d;
      if (we.lat)   lat   <= lat_d;
      if (we.iline) iline <= iline_d;
      if (we.rom)   rom   <= rom_d;
    end
  end

  assert_cmd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !we.cmd |=> $stable(cmd));
  assert_rom_probe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (we.rom && wdata == ROM_PROBE_VAL) |=> (rom == '1));
  assert_iline_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !we.iline |=> $stable(iline));

endmodule

// File: rtl/cfgsp_bar_slot.sv
module cfgsp_bar_slot
  import cfgsp_pkg::*;
#(
  parameter logic [31:0] SIZE     = 32'h1000,
  parameter logic [31:0] INIT     = 32'h0,
  parameter logic [31:0] LEG_BASE = 32'h0,
  parameter bit          LEGACY   = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] val,
  output logic [WORD_W-1:0] addr,
  output logic              pulse
);

  localparam logic [WORD_W-1:0] SIZE_MASK = ~(SIZE - 32'd1);
  localparam logic [WORD_W-1:0] LEG_ADDR  = LEG_BASE + INIT;
  localparam logic [WORD_W-1:0] RST_VAL   = LEGACY ? '0 : INIT;

  if (!LEGACY && !pow2_or_zero(SIZE)) begin : g_bad_size
    $error("BAR size parameter must be zero or a power of two");
  end

  logic [WORD_W-1:0] val_q, addr_q, attr, cand, val_d;
  logic              we_eff, sizing, addr_upd, pulse_q;

  always_comb begin
    we_eff   = we && !LEGACY;
    attr     = val_q[0] ? IO_ATTR_MASK : MEM_ATTR_MASK;
    sizing   = (wdata == '1);
    cand     = sizing ? SIZE_MASK : (wdata & ~attr);
    val_d    = (cand & ~attr) | (val_q & attr);
    addr_upd = we_eff && !sizing && (cand != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q   <= RST_VAL;
      addr_q  <= '0;
      pulse_q <= 1'b0;
    end else begin
      if (we_eff)   val_q  <= val_d;
      if (addr_upd) addr_q <= cand;
      pulse_q <= addr_upd;
    end
  end

  assign val   = val_q;
  assign addr  = LEGACY ? LEG_ADDR : addr_q;
  assign pulse = pulse_q;

  assert_addr_only_on_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !pulse |-> $stable(addr));
  assert_sizing_no_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wdata == '1) |=> !pulse);
  assert_attr_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    we_eff |=> (val[1:0] == $past(val[1:0])));

endmodule

// File: rtl/cfg_space_responder.sv
module cfg_space_responder
  import cfgsp_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID   = 16'hABCD,
  parameter logic [15:0] DEVICE_ID   = 16'h0042,
  parameter logic [15:0] CMD_INIT    = 16'h0000,
  parameter logic [15:0] STAT_INIT   = 16'h0010,
  parameter logic [7:0]  REVISION    = 8'h03,
  parameter logic [7:0]  PROG_IF     = 8'h00,
  parameter logic [7:0]  SUB_CLASS   = 8'h00,
  parameter logic [7:0]  BASE_CLASS  = 8'h02,
  parameter logic [7:0]  CLS_INIT    = 8'h00,
  parameter logic [7:0]  LAT_INIT    = 8'h00,
  parameter logic [7:0]  HDR_TYPE    = 8'h00,
  parameter logic [7:0]  SELF_TEST   = 8'h00,
  parameter logic [31:0] CIS_PTR     = 32'h0,
  parameter logic [15:0] SUB_VENDOR  = 16'hABCD,
  parameter logic [15:0] SUB_ID      = 16'h0001,
  parameter logic [31:0] ROM_INIT    = 32'h0,
  parameter logic [7:0]  CAP_PTR     = 8'h00,
  parameter logic [7:0]  ILINE_INIT  = 8'h0A,
  parameter logic [7:0]  INT_PIN     = 8'h01,
  parameter logic [7:0]  MIN_GNT     = 8'h00,
  parameter logic [7:0]  MAX_LAT     = 8'h20,
  parameter logic [31:0] LEGACY_BASE = 32'h8000_0000,
  parameter logic [NUM_BARS*32-1:0] BAR_SIZES =
    {32'h0010_0000, 32'h0001_0000, 32'h0, 32'h8, 32'h100, 32'h1000},
  parameter logic [NUM_BARS*32-1:0] BAR_INITS =
    {32'h0, 32'h8, 32'h0, 32'h1F0, 32'h1, 32'h0},
  parameter logic [NUM_BARS-1:0] BAR_LEGACY = 6'b000100
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic                     req_write,
  input  logic [1:0]               req_size,
  input  logic [7:0]               req_offset,
  input  logic [31:0]              req_wdata,
  output logic                     rsp_ack,
  output logic [31:0]              rsp_rdata,
  output logic                     rsp_err,
  output logic [NUM_BARS*32-1:0]   bar_addr,
  output logic                     bar_range_chg
);

  if (INT_PIN > 8'd4) begin : g_bad_pin
    $error("interrupt pin parameter must be 0 to 4");
  end

  hdr_we_t             hdr_we;
  logic [NUM_BARS-1:0] bar_we, bar_pulse;
  logic                dec_err;
  logic [WORD_W-1:0]   bar_val [NUM_BARS];
  logic [15:0]         cmd, stat;
  logic [7:0]          cls, lat, iline;
  logic [WORD_W-1:0]   rom;
  logic [HDR_BITS-1:0] hdr_flat;
  logic [WORD_W-1:0]   rd_val, rdata_d;
  logic                ack_q, err_q;
  logic [WORD_W-1:0]   rdata_q;

  cfgsp_decode u_decode (
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_size   (req_size),
    .req_offset (req_offset),
    .hdr_we     (hdr_we),
    .bar_we     (bar_we),
    .bad_access (dec_err)
  );

  cfgsp_hdr_regs #(
    .CMD_INIT (CMD_INIT), .STAT_INIT (STAT_INIT), .CLS_INIT (CLS_INIT),
    .LAT_INIT (LAT_INIT), .ILINE_INIT (ILINE_INIT), .ROM_INIT (ROM_INIT)
  ) u_hdr (
    .clk (clk), .rst_n (rst_n), .we (hdr_we), .wdata (req_wdata),
    .cmd (cmd), .stat (stat), .cls (cls), .lat (lat), .iline (iline), .rom (rom)
  );

  for (genvar gb = 0; gb < NUM_BARS; gb++) begin : g_bar
    cfgsp_bar_slot #(
      .SIZE     (BAR_SIZES[gb*32 +: 32]),
      .INIT     (BAR_INITS[gb*32 +: 32]),
      .LEG_BASE (LEGACY_BASE),
      .LEGACY   (BAR_LEGACY[gb])
    ) u_slot (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (bar_we[gb]),
      .wdata (req_wdata),
      .val   (bar_val[gb]),
      .addr  (bar_addr[gb*32 +: 32]),
      .pulse (bar_pulse[gb])
    );
  end

  // Header image, byte k at bits 8k+7:8k; reserved bytes stay zero
  always_comb begin
    hdr_flat = '0;
    hdr_flat[0   +: 16] = VENDOR_ID;
    hdr_flat[16  +: 16] = DEVICE_ID;
    hdr_flat[32  +: 16] = cmd;
    hdr_flat[48  +: 16] = stat;
    hdr_flat[64  +: 8]  = REVISION;
    hdr_flat[72  +: 8]  = PROG_IF;
    hdr_flat[80  +: 8]  = SUB_CLASS;
    hdr_flat[88  +: 8]  = BASE_CLASS;
    hdr_flat[96  +: 8]  = cls;
    hdr_flat[104 +: 8]  = lat;
    hdr_flat[112 +: 8]  = HDR_TYPE;
    hdr_flat[120 +: 8]  = SELF_TEST;
    for (int b = 0; b < NUM_BARS; b++) begin
      hdr_flat[(int'(OFF_BAR0) + 4 * b) * 8 +: 32] = bar_val[b];
    end
    hdr_flat[320 +: 32] = CIS_PTR;
    hdr_flat[352 +: 16] = SUB_VENDOR;
    hdr_flat[368 +: 16] = SUB_ID;
    hdr_flat[384 +: 32] = rom;
    hdr_flat[416 +: 8]  = CAP_PTR;
    hdr_flat[480 +: 8]  = iline;
    hdr_flat[488 +: 8]  = INT_PIN;
    hdr_flat[496 +: 8]  = MIN_GNT;
    hdr_flat[504 +: 8]  = MAX_LAT;
  end

  // Little-endian gather of up to four bytes
  always_comb begin
    logic [8:0] idx;
    int         nbytes;
    unique case (acc_size_e'(req_size))
      SZ_BYTE: nbytes = 1;
      SZ_HALF: nbytes = 2;
      SZ_WORD: nbytes = 4;
      default: nbytes = 0;
    endcase
    rd_val = '0;
    for (int k = 0; k < 4; k++) begin
      idx = {1'b0, req_offset} + 9'(k);
      if (k < nbytes && idx < 9'(HDR_BYTES)) begin
        rd_val[8*k +: 8] = hdr_flat[{idx[5:0], 3'b000} +: 8];
      end
    end
    rdata_d = req_write ? '0 : rd_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q   <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      ack_q <= req_valid;
      err_q <= dec_err;
      if (req_valid) rdata_q <= rdata_d;
    end
  end

  assign rsp_ack       = ack_q;
  assign rsp_err       = err_q;
  assign rsp_rdata     = rdata_q;
  assign bar_range_chg = |bar_pulse;

  assert_ack_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_ack);
  assert_no_spurious_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_ack);
  assert_err_with_ack_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_ack);
  assert_bad_size_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size == 2'd3) |=> (rsp_err && rsp_rdata == '0));
  assert_pulse_with_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bar_range_chg |-> rsp_ack);

endmodule

// File: tb/cfg_space_responder_test.sv
module cfg_space_responder_test;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         req_valid, req_write;
  logic [1:0]   req_size;
  logic [7:0]   req_offset;
  logic [31:0]  req_wdata;
  logic         rsp_ack, rsp_err, bar_range_chg;
  logic [31:0]  rsp_rdata;
  logic [191:0] bar_addr;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  logic        s_ack, s_err, s_pulse;
  logic [31:0] s_rdata;

  always #5 clk = ~clk;

  cfg_space_responder uut (
    .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_write (req_write),
    .req_size (req_size), .req_offset (req_offset), .req_wdata (req_wdata),
    .rsp_ack (rsp_ack), .rsp_rdata (rsp_rdata), .rsp_err (rsp_err),
    .bar_addr (bar_addr), .bar_range_chg (bar_range_chg)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic        wr;
    logic [1:0]  sz;
    logic [7:0]  off;
    logic [31:0] wd;
    logic [31:0] exp;
    logic        err;
  } vec_t;

  localparam int NV = 61;
  localparam vec_t VECS [NV] = '{
    // R11 reset contents
    '{4'd11, 1'b0, 2'd2, 8'h00, 32'h0, 32'h0042ABCD, 1'b0},
    '{4'd11, 1'b0, 2'd2, 8'h08, 32'h0, 32'h02000003, 1'b0},
    '{4'd11, 1'b0, 2'd2, 8'h34, 32'h0, 32'h00000000, 1'b0},
    '{4'd11, 1'b0, 2'd2, 8'h38, 32'h0, 32'h00000000, 1'b0},
    '{4'd11, 1'b0, 2'd2, 8'h3C, 32'h0, 32'h2000010A, 1'b0},
    // R2 byte lanes and unaligned reads
    '{4'd2, 1'b0, 2'd0, 8'h3D, 32'h0, 32'h00000001, 1'b0},
    '{4'd2, 1'b0, 2'd1, 8'h02, 32'h0, 32'h00000042, 1'b0},
    '{4'd2, 1'b0, 2'd1, 8'h01, 32'h0, 32'h000042AB, 1'b0},
    // R3 device-specific region
    '{4'd3, 1'b0, 2'd2, 8'h40, 32'h0, 32'h00000000, 1'b0},
    '{4'd3, 1'b0, 2'd2, 8'h3E, 32'h0, 32'h00002000, 1'b0},
    '{4'd3, 1'b1, 2'd2, 8'h80, 32'hFFFFFFFF, 32'h0, 1'b0},
    '{4'd3, 1'b0, 2'd2, 8'h80, 32'h0, 32'h00000000, 1'b0},
    // R1 invalid size code
    '{4'd1, 1'b1, 2'd3, 8'h04, 32'h0000FFFF, 32'h0, 1'b1},
    '{4'd1, 1'b0, 2'd1, 8'h04, 32'h0, 32'h00000000, 1'b0},
    '{4'd1, 1'b0, 2'd3, 8'h00, 32'h0, 32'h00000000, 1'b1},
    // R9 byte writes
    '{4'd9, 1'b1, 2'd0, 8'h3C, 32'h55, 32'h0, 1'b0},
    '{4'd9, 1'b0, 2'd0, 8'h3C, 32'h0, 32'h00000055, 1'b0},
    '{4'd9, 1'b1, 2'd0, 8'h0C, 32'h10, 32'h0, 1'b0},
    '{4'd9, 1'b1, 2'd0, 8'h0D, 32'h40, 32'h0, 1'b0},
    '{4'd9, 1'b0, 2'd1, 8'h0C, 32'h0, 32'h00004010, 1'b0},
    '{4'd9, 1'b1, 2'd0, 8'h3D, 32'h07, 32'h0, 1'b0},
    '{4'd9, 1'b0, 2'd0, 8'h3D, 32'h0, 32'h00000001, 1'b0},
    '{4'd9, 1'b1, 2'd0, 8'h08, 32'hEE, 32'h0, 1'b0},
    '{4'd9, 1'b0, 2'd0, 8'h08, 32'h0, 32'h00000003, 1'b0},
    '{4'd9, 1'b1, 2'd0, 8'h00, 32'h11, 32'h0, 1'b1},
    '{4'd9, 1'b0, 2'd0, 8'h00, 32'h0, 32'h000000CD, 1'b0},
    // R10 half and word writes
    '{4'd10, 1'b1, 2'd1, 8'h04, 32'h0147, 32'h0, 1'b0},
    '{4'd10, 1'b0, 2'd1, 8'h04, 32'h0, 32'h00000147, 1'b0},
    '{4'd10, 1'b1, 2'd1, 8'h06, 32'h0290, 32'h0, 1'b0},
    '{4'd10, 1'b0, 2'd2, 8'h04, 32'h0, 32'h02900147, 1'b0},
    '{4'd10, 1'b1, 2'd1, 8'h0C, 32'h0020, 32'h0, 1'b0},
    '{4'd10, 1'b0, 2'd1, 8'h0C, 32'h0, 32'h00004020, 1'b0},
    '{4'd10, 1'b1, 2'd2, 8'h04, 32'hAAAA0006, 32'h0, 1'b0},
    '{4'd10, 1'b0, 2'd2, 8'h04, 32'h0, 32'h02900006, 1'b0},
    '{4'd10, 1'b1, 2'd1, 8'h00, 32'h1234, 32'h0, 1'b1},
    '{4'd10, 1'b0, 2'd1, 8'h00, 32'h0, 32'h0000ABCD, 1'b0},
    '{4'd10, 1'b1, 2'd2, 8'h2C, 32'h0, 32'h0, 1'b1},
    '{4'd10, 1'b0, 2'd2, 8'h2C, 32'h0, 32'h0001ABCD, 1'b0},
    // R8 expansion ROM
    '{4'd8, 1'b1, 2'd2, 8'h30, 32'hFFFFFFFE, 32'h0, 1'b0},
    '{4'd8, 1'b0, 2'd2, 8'h30, 32'h0, 32'hFFFFFFFF, 1'b0},
    '{4'd8, 1'b1, 2'd2, 8'h30, 32'h000C0001, 32'h0, 1'b0},
    '{4'd8, 1'b0, 2'd2, 8'h30, 32'h0, 32'h000C0001, 1'b0},
    // R4 sizing
    '{4'd4, 1'b1, 2'd2, 8'h10, 32'hFFFFFFFF, 32'h0, 1'b0},
    '{4'd4, 1'b0, 2'd2, 8'h10, 32'h0, 32'hFFFFF000, 1'b0},
    '{4'd4, 1'b1, 2'd2, 8'h14, 32'hFFFFFFFF, 32'h0, 1'b0},
    '{4'd4, 1'b0, 2'd2, 8'h14, 32'h0, 32'hFFFFFF01, 1'b0},
    '{4'd4, 1'b1, 2'd2, 8'h1C, 32'hFFFFFFFF, 32'h0, 1'b0},
    '{4'd4, 1'b0, 2'd2, 8'h1C, 32'h0, 32'h00000000, 1'b0},
    '{4'd4, 1'b1, 2'd2, 8'h20, 32'hFFFFFFFF, 32'h0, 1'b0},
    '{4'd4, 1'b0, 2'd2, 8'h20, 32'h0, 32'hFFFF0008, 1'b0},
    // R5 attribute preservation
    '{4'd5, 1'b1, 2'd2, 8'h10, 32'h80000007, 32'h0, 1'b0},
    '{4'd5, 1'b0, 2'd2, 8'h10, 32'h0, 32'h80000000, 1'b0},
    '{4'd5, 1'b1, 2'd2, 8'h14, 32'h0000C003, 32'h0, 1'b0},
    '{4'd5, 1'b0, 2'd2, 8'h14, 32'h0, 32'h0000C001, 1'b0},
    '{4'd5, 1'b1, 2'd2, 8'h20, 32'h12345673, 32'h0, 1'b0},
    '{4'd5, 1'b0, 2'd2, 8'h20, 32'h0, 32'h12345678, 1'b0},
    // R7 legacy BAR
    '{4'd7, 1'b0, 2'd2, 8'h18, 32'h0, 32'h00000000, 1'b0},
    '{4'd7, 1'b1, 2'd2, 8'h18, 32'hFFFFFFFF, 32'h0, 1'b0},
    '{4'd7, 1'b0, 2'd2, 8'h18, 32'h0, 32'h00000000, 1'b0},
    '{4'd7, 1'b1, 2'd2, 8'h18, 32'h00004001, 32'h0, 1'b0},
    '{4'd7, 1'b0, 2'd2, 8'h18, 32'h0, 32'h00000000, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  // One request, outputs sampled on the following falling edge
  task automatic xfer(input logic wr, input logic [1:0] sz, input logic [7:0] off,
                      input logic [31:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_size = sz; req_offset = off; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_wdata = '0;
    s_ack = rsp_ack; s_err = rsp_err; s_rdata = rsp_rdata; s_pulse = bar_range_chg;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_size = 2'd0; req_offset = 8'h0; req_wdata = '0;
    do_reset();

    // R11 reset outputs
    chk("R11 ack low",       {31'b0, rsp_ack},       32'h0);
    chk("R11 err low",       {31'b0, rsp_err},       32'h0);
    chk("R11 pulse low",     {31'b0, bar_range_chg}, 32'h0);
    chk("R11 bar0 addr",     bar_addr[0 +: 32],      32'h0);
    chk("R11 bar4 addr",     bar_addr[128 +: 32],    32'h0);
    chk("R7 legacy addr",    bar_addr[64 +: 32],     32'h800001F0);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      xfer(VECS[i].wr, VECS[i].sz, VECS[i].off, VECS[i].wd);
      chk($sformatf("R2 ack vec %0d", i), {31'b0, s_ack}, 32'h1);
      chk($sformatf("R%0d data vec %0d", VECS[i].req, i), s_rdata, VECS[i].exp);
      chk($sformatf("R%0d err vec %0d", VECS[i].req, i), {31'b0, s_err}, {31'b0, VECS[i].err});
    end

    // R6 decoded addresses after the table
    chk("R6 bar0 addr", bar_addr[0 +: 32],   32'h80000000);
    chk("R6 bar1 addr", bar_addr[32 +: 32],  32'h0000C000);
    chk("R6 bar4 addr", bar_addr[128 +: 32], 32'h12345670);
    chk("R4 bar3 addr", bar_addr[96 +: 32],  32'h0);
    chk("R7 legacy addr kept", bar_addr[64 +: 32], 32'h800001F0);

    // R6 back-to-back: BAR write then read of it with no idle cycle
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_size = 2'd2; req_offset = 8'h10;
    req_wdata = 32'h40000000;
    @(negedge clk);
    req_write = 1'b0; req_wdata = '0;
    chk("R6 write ack",   {31'b0, rsp_ack},       32'h1);
    chk("R6 pulse",       {31'b0, bar_range_chg}, 32'h1);
    chk("R6 new addr",    bar_addr[0 +: 32],      32'h40000000);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 read ack",    {31'b0, rsp_ack},       32'h1);
    chk("R6 read back",   rsp_rdata,              32'h40000000);
    chk("R6 pulse drop",  {31'b0, bar_range_chg}, 32'h0);
    @(negedge clk);
    chk("R2 idle no ack", {31'b0, rsp_ack},       32'h0);

    // R6 write masking to zero: no pulse, address held
    xfer(1'b1, 2'd2, 8'h10, 32'h00000003);
    chk("R6 zero no pulse", {31'b0, s_pulse},     32'h0);
    chk("R6 zero addr kept", bar_addr[0 +: 32],   32'h40000000);
    // R4 sizing write: no pulse, address held
    xfer(1'b1, 2'd2, 8'h10, 32'hFFFFFFFF);
    chk("R4 sizing no pulse", {31'b0, s_pulse},   32'h0);
    chk("R4 sizing addr kept", bar_addr[0 +: 32], 32'h40000000);
    // R7 legacy write: no pulse
    xfer(1'b1, 2'd2, 8'h18, 32'h12340000);
    chk("R7 legacy no pulse", {31'b0, s_pulse},   32'h0);

    // R11 second reset restores parameters
    do_reset();
    chk("R11 ack after reset",  {31'b0, rsp_ack}, 32'h0);
    chk("R11 bar0 addr reset",  bar_addr[0 +: 32], 32'h0);
    chk("R11 bar1 addr reset",  bar_addr[32 +: 32], 32'h0);
    xfer(1'b0, 2'd2, 8'h04, 32'h0);
    chk("R11 cmd/status reset", s_rdata, 32'h00100000);
    xfer(1'b0, 2'd2, 8'h14, 32'h0);
    chk("R11 bar1 value reset", s_rdata, 32'h00000001);
    xfer(1'b0, 2'd2, 8'h30, 32'h0);
    chk("R11 rom reset",        s_rdata, 32'h0);
    xfer(1'b0, 2'd0, 8'h3C, 32'h0);
    chk("R11 iline reset",      s_rdata, 32'h0000000A);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule